// File: doc/BRIEF.md
# Glitch-Free Clock Group Stop and Standby Controller

This block sits at the outputs of a motherboard clock generator. It receives clocks that are already generated: a fast processor clock, a slower bus clock, a 48 MHz clock and a reference clock. It passes them to the board in groups, and each group can be stopped and started without producing a shortened pulse. Two processor clock outputs stop when the active-low processor stop request is low. Five bus clock outputs stop when the active-low bus stop request is low. A sixth bus clock output, along with the 48 MHz and reference outputs, is affected only by power-down.

When power-down is requested, the processor and bus groups stop first. After a drain interval the free-running outputs stop as well, and a standby flag rises. On wake-up the flag stays high for a programmable restart interval, counted in processor clock cycles, and all outputs then resume. Power-down takes priority over both stop requests.

A frequency-select strap is captured once after reset and presented to the clock source as the processor rate choice.

Every gate holds its clock LOW while stopped. The enable of each gate changes on the falling edge of the clock it gates, so each pulse is either passed whole or not passed at all.

Top module: `ckstop_ctrl`

## Requirements
- R1: After `cpu_stop_n` goes low, each of the two processor outputs shows 2 or 3 more rising edges and then stays LOW. Both processor outputs carry identical waveforms.
- R2: After `cpu_stop_n` returns high, the processor outputs rise again on the 3rd or 4th `cpu_clk` rising edge. No high or low phase on any gated processor or bus output is shorter than half its source period.
- R3: `pci_stop_n` is sampled on each rising edge of `pci_clk`. A low sample allows exactly one further rising edge on the gated bus outputs. A high sample that follows a stop lets the gated bus outputs rise on the next `pci_clk` rising edge, which is the second edge after the change.
- R4: The five gated bus outputs are always identical. While they are enabled they toggle once per `pci_clk` period. `pci_free` keeps toggling whatever the level of `pci_stop_n`.
- R5: After `pwr_dn_n` goes low, the processor and bus groups stop first. `DRAIN_CYC` processor cycles later the free-running, 48 MHz and reference outputs stop. Then `standby` rises. While `standby` is high, every clock output is LOW.
- R6: While power-down is in effect, a high `cpu_stop_n` or `pci_stop_n` does not restart any output.
- R7: After `pwr_dn_n` returns high, `standby` stays high for `RESTART_CYC` processor cycles plus the synchroniser delay. It then falls, and all outputs resume.
- R8: `cpu_rate_fast` takes the value of `rate_strap` on the first `cpu_clk` edge after reset. Later changes of the strap are ignored until the next reset.
- R9: While `rst_n` is low, every clock output and `standby` is LOW. After reset is released, all outputs start toggling within a few cycles of their own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor source clock; also clocks the power sequencer |
| pci_clk | input | 1 | Bus source clock |
| usb_clk | input | 1 | 48 MHz source clock |
| ref_clk | input | 1 | Reference source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low processor group stop request, asynchronous |
| pci_stop_n | input | 1 | Active-low bus group stop request, synchronous to pci_clk |
| pwr_dn_n | input | 1 | Active-low power-down request, asynchronous |
| rate_strap | input | 1 | Frequency-select strap (1 = 100 MHz, 0 = 66 MHz) |
| cpu_gclk | output | 2 | Gated processor clocks |
| pci_gclk | output | 5 | Gated bus clocks |
| pci_free | output | 1 | Bus clock stopped only by power-down |
| usb_out | output | 1 | 48 MHz clock stopped only by power-down |
| ref_out | output | 1 | Reference clock stopped only by power-down |
| standby | output | 1 | High while all outputs are held for power-down or restart |
| cpu_rate_fast | output | 1 | Captured strap value presented to the clock source |

## Verification
A wrong synchroniser depth or a wrong enable edge appears at the gated outputs within two or three source cycles of a request. It shows as a wrong count of trailing or leading pulses, or as a half-width pulse that the pulse-width monitor catches. A sequencer stuck in the wrong state appears within one drain or restart interval. The symptoms are `standby` staying high, a free-running clock still toggling while `standby` is high, or outputs that never resume. A lost strap capture shows on `cpu_rate_fast` in the first cycle after reset.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;
  typedef enum logic [2:0] {
    PS_RUN       = 3'd0,
    PS_DRAIN_RUN = 3'd1,
    PS_DRAIN_AUX = 3'd2,
    PS_STANDBY   = 3'd3,
    PS_WAKE      = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/ckstop_gate.sv
// Glitch-free gate for one clock group. An asynchronous request passes
// through SYNC_STAGES flops. A local request already in this clock domain
// passes through one flop. The combined enable is re-timed on the falling
// edge, so it changes only while the source clock is low.
module ckstop_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int WIDTH       = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_async,
  input  logic             req_local,
  output logic [WIDTH-1:0] gclk
);
  logic [SYNC_STAGES:0] chain;
  logic                 loc_q;
  logic                 en_q;

  assign chain[0] = req_async;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i+1] <= 1'b0;
      else        chain[i+1] <= chain[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loc_q <= 1'b0;
    else        loc_q <= req_local;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= chain[SYNC_STAGES] & loc_q;
  end

  assign gclk = {WIDTH{clk & en_q}};
endmodule

// File: rtl/ckstop_pwr_seq.sv
// Power-down sequencer in the processor clock domain.
module ckstop_pwr_seq
  import ckstop_pkg::*;
#(
  parameter int DRAIN_CYC   = 32,
  parameter int RESTART_CYC = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn_n,
  output logic run_allow,
  output logic aux_allow,
  output logic standby
);
  localparam int MAX_CYC = (DRAIN_CYC > RESTART_CYC) ? DRAIN_CYC : RESTART_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [1:0]       pd_sync;
  logic             pd_s;
  pwr_state_e       state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             counting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_sync <= 2'b11;
    else        pd_sync <= {pd_sync[0], pwr_dn_n};
  end
  assign pd_s = pd_sync[1];

  assign counting = (state == PS_DRAIN_RUN) || (state == PS_DRAIN_AUX) ||
                    (state == PS_WAKE);

  always_comb begin
    nxt = state;
    unique case (state)
      PS_RUN:       if (!pd_s) nxt = PS_DRAIN_RUN;
      PS_DRAIN_RUN: if (cnt == CNT_W'(DRAIN_CYC - 1)) nxt = PS_DRAIN_AUX;
      PS_DRAIN_AUX: if (cnt == CNT_W'(DRAIN_CYC - 1)) nxt = PS_STANDBY;
      PS_STANDBY:   if (pd_s) nxt = PS_WAKE;
      PS_WAKE: begin
        if (!pd_s)                                 nxt = PS_STANDBY;
        else if (cnt == CNT_W'(RESTART_CYC - 1)) nxt = PS_RUN;
      end
      default:      nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PS_RUN;
      cnt       <= '0;
      run_allow <= 1'b0;
      aux_allow <= 1'b0;
      standby   <= 1'b0;
    end else begin
      state     <= nxt;
      cnt       <= (nxt != state) ? '0 : (counting ? cnt + 1'b1 : cnt);
      run_allow <= (nxt == PS_RUN);
      aux_allow <= (nxt == PS_RUN) || (nxt == PS_DRAIN_RUN);
      standby   <= (nxt == PS_STANDBY) || (nxt == PS_WAKE);
    end
  end

  // R5
  stby_after_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> $past(!aux_allow));
  // R7
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !pd_s) |=> standby);
  // R7
  stby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby) |-> $past(pd_s));
endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl #(
  parameter int N_CPU       = 2,
  parameter int N_PCI       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int DRAIN_CYC   = 32,
  parameter int RESTART_CYC = 300000
) (
  input  logic             cpu_clk,
  input  logic             pci_clk,
  input  logic             usb_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_dn_n,
  input  logic             rate_strap,
  output logic [N_CPU-1:0] cpu_gclk,
  output logic [N_PCI-1:0] pci_gclk,
  output logic             pci_free,
  output logic             usb_out,
  output logic             ref_out,
  output logic             standby
  ,output logic            cpu_rate_fast
);
  logic run_allow, aux_allow, strap_taken;

  ckstop_pwr_seq #(.DRAIN_CYC(DRAIN_CYC), .RESTART_CYC(RESTART_CYC)) u_seq (
    .clk(cpu_clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n),
    .run_allow(run_allow), .aux_allow(aux_allow), .standby(standby));

  // Processor group: asynchronous stop request, sequencer permission is local.
  ckstop_gate #(.SYNC_STAGES(SYNC_STAGES), .WIDTH(N_CPU)) u_cpu_gate (
    .clk(cpu_clk), .rst_n(rst_n), .req_async(cpu_stop_n),
    .req_local(run_allow), .gclk(cpu_gclk));

  // Bus group: the stop request is latched directly on the bus clock edge.
  ckstop_gate #(.SYNC_STAGES(SYNC_STAGES), .WIDTH(N_PCI)) u_pci_gate (
    .clk(pci_clk), .rst_n(rst_n), .req_async(run_allow),
    .req_local(pci_stop_n), .gclk(pci_gclk));

  ckstop_gate #(.SYNC_STAGES(SYNC_STAGES), .WIDTH(1)) u_free_gate (
    .clk(pci_clk), .rst_n(rst_n), .req_async(aux_allow),
    .req_local(1'b1), .gclk(pci_free));

  ckstop_gate #(.SYNC_STAGES(SYNC_STAGES), .WIDTH(1)) u_usb_gate (
    .clk(usb_clk), .rst_n(rst_n), .req_async(aux_allow),
    .req_local(1'b1), .gclk(usb_out));

  ckstop_gate #(.SYNC_STAGES(SYNC_STAGES), .WIDTH(1)) u_ref_gate (
    .clk(ref_clk), .rst_n(rst_n), .req_async(aux_allow),
    .req_local(1'b1), .gclk(ref_out));

  // Strap captured once after reset
  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_taken   <= 1'b0;
      cpu_rate_fast <= 1'b0;
    end else if (!strap_taken) begin
      strap_taken   <= 1'b1;
      cpu_rate_fast <= rate_strap;
    end
  end

  // R5
  stby_quiet_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    standby |-> (cpu_gclk == '0 && pci_gclk == '0 && !pci_free && !usb_out && !ref_out));
  // R8
  strap_hold_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    strap_taken |=> $stable(cpu_rate_fast));
  // R4
  pci_same_chk: assert property (@(posedge pci_clk) disable iff (!rst_n)
    (pci_gclk == '0) || (pci_gclk == '1));
endmodule

// File: tb/ckstop_ctrl_bench.sv
`timescale 1ns/100ps
module ckstop_ctrl_bench;
  localparam int DRAIN   = 32;
  localparam int RESTART = 60;

  logic cpu_clk = 0, pci_clk = 0, usb_clk = 0, ref_clk = 0;
  logic rst_n = 0, cpu_stop_n = 1, pci_stop_n = 1, pwr_dn_n = 1, rate_strap = 1;
  logic [1:0] cpu_gclk;
  logic [4:0] pci_gclk;
  logic pci_free, usb_out, ref_out, standby, cpu_rate_fast;

  always #2 cpu_clk = ~cpu_clk;
  always #6 pci_clk = ~pci_clk;
  always #5 usb_clk = ~usb_clk;
  always #7 ref_clk = ~ref_clk;

  ckstop_ctrl #(.DRAIN_CYC(DRAIN), .RESTART_CYC(RESTART)) u_ckstop_ctrl (
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .usb_clk(usb_clk), .ref_clk(ref_clk),
    .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwr_dn_n(pwr_dn_n), .rate_strap(rate_strap), .cpu_gclk(cpu_gclk),
    .pci_gclk(pci_gclk), .pci_free(pci_free), .usb_out(usb_out),
    .ref_out(ref_out), .standby(standby), .cpu_rate_fast(cpu_rate_fast));

  int checks = 0, fails = 0;
  bit done = 0;
  int n_cpu0 = 0, n_cpu1 = 0, n_pci = 0, n_free = 0, n_usb = 0, n_ref = 0;
  int runts = 0, pci_mism = 0;
  realtime t_cpu = 0.0, t_pci = 0.0;

  always @(posedge cpu_gclk[0]) n_cpu0++;
  always @(posedge cpu_gclk[1]) n_cpu1++;
  always @(posedge pci_gclk[0]) n_pci++;
  always @(posedge pci_free)    n_free++;
  always @(posedge usb_out)     n_usb++;
  always @(posedge ref_out)     n_ref++;
  always @(cpu_gclk[0]) begin
    if (t_cpu > 0.0 && ($realtime - t_cpu) < 1.9) runts++;
    t_cpu = $realtime;
  end
  always @(pci_gclk[0]) begin
    if (t_pci > 0.0 && ($realtime - t_pci) < 5.9) runts++;
    t_pci = $realtime;
  end
  always @(pci_gclk) if (pci_gclk != 5'h00 && pci_gclk != 5'h1f) pci_mism++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cpu(input int n);
    repeat (n) @(posedge cpu_clk);
    #0.5;
  endtask

  task automatic wait_pci(input int n);
    repeat (n) @(posedge pci_clk);
    #0.5;
  endtask

  task automatic t_reset(input bit strap);
    rst_n = 0; rate_strap = strap;
    wait_cpu(6);
    chk(cpu_gclk == 0 && pci_gclk == 0 && !pci_free && !usb_out && !ref_out,
        "R9", "outputs low in reset", {cpu_gclk, pci_gclk}, 0);
    chk(standby == 0, "R9", "standby in reset", standby, 0);
    rst_n = 1;
    wait_cpu(2);
    chk(cpu_rate_fast == strap, "R8", "strap capture", cpu_rate_fast, strap);
    wait_cpu(30);
  endtask

  task automatic t_running();
    int b0, b1, bp, bf, bu, br;
    b0 = n_cpu0; b1 = n_cpu1; bp = n_pci; bf = n_free; bu = n_usb; br = n_ref;
    wait_cpu(30);
    chk(n_cpu0 - b0 == 30, "R9", "cpu edges in 30 cycles", n_cpu0 - b0, 30);
    chk(n_cpu1 - b1 == 30, "R1", "cpu1 matches cpu0", n_cpu1 - b1, 30);
    chk(n_usb > bu && n_ref > br && n_free > bf, "R9", "aux toggling", n_usb - bu, 1);
    bp = n_pci;
    wait_pci(10);
    chk(n_pci - bp == 10, "R4", "pci edges in 10 cycles", n_pci - bp, 10);
  endtask

  task automatic t_cpu_stop();
    int b, n;
    wait_cpu(1);
    b = n_cpu0;
    cpu_stop_n = 0;
    wait_cpu(8);
    chk((n_cpu0 - b) >= 2 && (n_cpu0 - b) <= 3, "R1", "trailing cpu edges", n_cpu0 - b, 2);
    b = n_cpu0;
    wait_cpu(12);
    chk(n_cpu0 == b && cpu_gclk == 0, "R1", "cpu held low", n_cpu0 - b, 0);
    cpu_stop_n = 1;
    n = 0;
    while (n < 10) begin
      @(posedge cpu_clk); n++; #0.5;
      if (cpu_gclk[0]) break;
    end
    chk(n >= 3 && n <= 4, "R2", "cpu resume edge index", n, 3);
    wait_cpu(4);
    chk(n_cpu0 == n_cpu1, "R1", "cpu outputs identical", n_cpu1, n_cpu0);
  endtask

  task automatic t_pci_stop();
    int b, bf, n;
    wait_pci(1);
    b = n_pci; bf = n_free;
    pci_stop_n = 0;
    wait_pci(6);
    chk(n_pci - b == 1, "R3", "trailing pci edges", n_pci - b, 1);
    chk(n_free - bf == 6, "R4", "free pci unaffected", n_free - bf, 6);
    chk(pci_gclk == 0, "R3", "pci held low", pci_gclk, 0);
    pci_stop_n = 1;
    n = 0;
    while (n < 10) begin
      @(posedge pci_clk); n++; #0.5;
      if (pci_gclk[0]) break;
    end
    chk(n == 2, "R3", "pci resume edge index", n, 2);
  endtask

  task automatic t_power();
    int b0, bp, bf, bu, br;
    wait_cpu(1);
    pwr_dn_n = 0;
    wait_cpu(2 * DRAIN + 6);
    chk(standby == 1, "R5", "standby raised", standby, 1);
    b0 = n_cpu0; bp = n_pci; bf = n_free; bu = n_usb; br = n_ref;
    cpu_stop_n = 0; wait_cpu(5); cpu_stop_n = 1;
    pci_stop_n = 0; wait_cpu(5); pci_stop_n = 1;
    wait_cpu(30);
    chk(n_cpu0 == b0 && n_pci == bp, "R6", "stop inputs ignored in power-down",
        n_cpu0 - b0 + n_pci - bp, 0);
    chk(n_free == bf && n_usb == bu && n_ref == br, "R5", "free outputs held low",
        n_free - bf + n_usb - bu + n_ref - br, 0);
    pwr_dn_n = 1;
    wait_cpu(RESTART / 2);
    chk(standby == 1, "R7", "standby during restart", standby, 1);
    wait_cpu(RESTART / 2 + 10);
    chk(standby == 0, "R7", "standby cleared", standby, 1'b0);
    b0 = n_cpu0; bp = n_pci; bf = n_free; bu = n_usb; br = n_ref;
    wait_cpu(30);
    chk(n_cpu0 > b0 && n_pci > bp && n_free > bf && n_usb > bu && n_ref > br,
        "R7", "all outputs resumed", n_cpu0 - b0, 30);
  endtask

  task automatic t_strap_change();
    rate_strap = 0;
    wait_cpu(10);
    chk(cpu_rate_fast == 1, "R8", "strap change ignored", cpu_rate_fast, 1);
  endtask

  initial begin
    t_reset(1'b1);
    t_running();
    t_cpu_stop();
    t_pci_stop();
    t_power();
    t_strap_change();
    chk(runts == 0, "R2", "runt pulses", runts, 0);
    chk(pci_mism == 0, "R4", "pci outputs differ", pci_mism, 0);
    t_reset(1'b0);
    t_running();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule